// File: doc/BRIEF.md
# Serial Byte Receiver with Protected Holding Register

This block turns an asynchronous serial line into bytes and presents them through one holding register that software reads over a small register port. A frame is a low start bit, eight data bits sent least significant bit first, and one high stop bit. The line is sampled on a 16x oversampling strobe supplied from outside, and each bit is taken near its middle once the start bit has been confirmed. Line faults are reported through a status register and a single interrupt output. A stop bit that samples low is a framing fault. A frame whose data and stop bits are all low is a break.

The holding register never loses a byte that software has not yet read. When another frame finishes while the held byte is still unread, the held byte stays in place. The overrun, and any break that caused it, is kept out of sight until software reads the held byte. Clearing the overrun then takes a status read followed by a second data read. In addressed mode every frame carries a ninth bit that marks it as an address. Data frames reach the holding register only after an address frame that equals a programmable match value.

Top module: `uart_rx_ovp`

## Requirements
- R1: A frame is a low start bit, 8 data bits least significant first, then a stop bit. The frame is timed in units of 16 `baud_tick` strobes, and every bit is sampled near its middle. A low pulse on `rx_i` shorter than half a bit time does not start a frame. Once the stop bit has been sampled, the byte is readable at address 0, and status bit 0 (data available) is 1.
- R2: Control bit 0 (data interrupt enable) gates only the data-available source. `irq_o` is high when status bit 0 is 1 and control bit 0 is 1. The error sources of R3, R4 and R6 raise `irq_o` whatever control bit 0 holds.
- R3: A stop bit that samples low stores the byte and sets status bit 3 (framing fault) together with it, and `irq_o` goes high. A data read that frees the register clears status bits 0, 2 and 3.
- R4: A frame whose data bits and stop bit are all low stores 0x00 and sets status bits 2 (break) and 3. While the line stays low after a break, no new frame starts; a new frame can start only after `rx_i` has returned high.
- R5: When a frame completes while status bit 0 is 1 (overrun), the holding register keeps its byte. Status bit 1 (overrun) stays 0 until the next data read, while `irq_o` goes high.
- R6: The first data read after an overrun returns the held byte. After that read, status bit 1 is 1 and status bit 0 stays 1. Status bit 2 is 1 if any of the overrunning frames was a break.
- R7: After a status read that shows bit 1 set, the next data read clears status bits 0 to 3. A data read made before that status read changes no status bit. The holding register keeps its byte until another frame is stored.
- R8: When a data read and a frame completion fall in the same clock cycle, the read takes effect first. The read returns the old byte, the new byte is stored, status bit 0 is 1, and no overrun is recorded.
- R9: Control bit 1 selects addressed mode. In this mode a ninth bit follows the 8 data bits. A ninth bit of 1 marks an address frame: it is never stored, and if its stop bit is high it sets the match state to (byte equals the value at address 3). A data frame (ninth bit 0) is stored only while the match state is set; otherwise it is dropped with no status change.
- R10: The register map is: address 0 is data (read-only), address 1 is status (read-only, bits above 3 are zero), address 2 is control (bits 1:0 read and write), and address 3 is the match value (read and write). After reset, status, control and `irq_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | One-cycle strobe at 16x the bit rate |
| rx_i | input | 1 | Serial input, idle high |
| reg_rd | input | 1 | Read strobe; read side effects apply at the clock edge |
| reg_wr | input | 1 | Write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from `reg_addr` |
| irq_o | output | 1 | Combined receiver interrupt |

## Verification
The collision of interest is a data-register read that lands in the same cycle as a frame completion. The bench first times an undisturbed frame from a tick-aligned start, counting clock edges until the interrupt rises. It then replays an identical frame over an unread byte and pulses the read strobe on exactly that edge. The result is judged by the returned old byte, by the new byte taking its place, and by status showing data available with no overrun. The protected holding register is also exercised against overrun, break-caused overrun and the status-read-then-data-read clearing order. Address filtering is exercised in addressed mode.

// File: rtl/uart_rx_ovp_pkg.sv
package uart_rx_ovp_pkg;

  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_DATA  = 2'd2,
    RX_STOP  = 2'd3
  } rx_state_e;

  localparam int STAT_W = 4;

  // Holding-register condition flags
  typedef struct packed {
    logic rda;       // byte present
    logic ferr;      // held byte had a low stop bit
    logic brk;       // held byte was a break
    logic ovr_pend;  // overrun seen, not yet shown
    logic brk_pend;  // a pending overrun came from a break
    logic ovr_vis;   // overrun shown in status
    logic brk_vis;   // break shown along with overrun
    logic seen;      // status read while overrun shown
  } hold_flags_t;

endpackage

// File: rtl/uart_rx_ovp_sync.sv
module uart_rx_ovp_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= {STAGES{RST_VAL}};
    else        pipe_q <= {pipe_q[STAGES-2:0], d};
  end

  assign q = pipe_q[STAGES-1];

endmodule

// File: rtl/uart_rx_ovp_deser.sv
module uart_rx_ovp_deser
  import uart_rx_ovp_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              rx,
  input  logic              mp_en,
  output logic              done,
  output logic [DATA_W-1:0] data,
  output logic              tag,
  output logic              stop_ok,
  output logic              brk
);

  localparam int CNT_W = $clog2(OVS);
  localparam int SH_W  = DATA_W + 1;
  localparam int IDX_W = $clog2(SH_W + 1);
  localparam logic [CNT_W-1:0] MID  = CNT_W'(OVS/2 - 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(OVS - 1);

  rx_state_e        st_q, st_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [IDX_W-1:0] idx_q, idx_n;
  logic [SH_W-1:0]  sh_q, sh_n;
  logic             armed_q, armed_n;
  logic [IDX_W-1:0] last_idx;

  assign last_idx = mp_en ? IDX_W'(SH_W - 1) : IDX_W'(DATA_W - 1);

  always_comb begin
    st_n    = st_q;
    cnt_n   = cnt_q;
    idx_n   = idx_q;
    sh_n    = sh_q;
    armed_n = armed_q;
    done    = 1'b0;
    if (st_q == RX_IDLE && rx) armed_n = 1'b1;
    if (tick) begin
      unique case (st_q)
        RX_IDLE: begin
          if (!rx && armed_q) begin
            st_n  = RX_START;
            cnt_n = '0;
          end
        end
        RX_START: begin
          if (cnt_q == MID) begin
            cnt_n = '0;
            idx_n = '0;
            sh_n  = '0;
            st_n  = rx ? RX_IDLE : RX_DATA;
          end else begin
            cnt_n = cnt_q + 1'b1;
          end
        end
        RX_DATA: begin
          if (cnt_q == LAST) begin
            cnt_n       = '0;
            sh_n[idx_q] = rx;
            if (idx_q == last_idx) st_n = RX_STOP;
            else                   idx_n = idx_q + 1'b1;
          end else begin
            cnt_n = cnt_q + 1'b1;
          end
        end
        RX_STOP: begin
          if (cnt_q == LAST) begin
            done    = 1'b1;
            cnt_n   = '0;
            st_n    = RX_IDLE;
            armed_n = rx;
          end else begin
            cnt_n = cnt_q + 1'b1;
          end
        end
        default: st_n = RX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= RX_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      sh_q    <= '0;
      armed_q <= 1'b0;
    end else begin
      st_q    <= st_n;
      cnt_q   <= cnt_n;
      idx_q   <= idx_n;
      sh_q    <= sh_n;
      armed_q <= armed_n;
    end
  end

  assign data    = sh_q[DATA_W-1:0];
  assign tag     = sh_q[DATA_W];
  assign stop_ok = rx;
  assign brk     = (sh_q == '0) && !rx;

endmodule

// File: rtl/uart_rx_ovp_hold.sv
module uart_rx_ovp_hold
  import uart_rx_ovp_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld,
  input  logic [DATA_W-1:0] ld_data,
  input  logic              ld_ferr,
  input  logic              ld_brk,
  input  logic              rd_data,
  input  logic              rd_stat,
  input  logic              rda_ie,
  output logic [DATA_W-1:0] data_q,
  output logic [STAT_W-1:0] stat,
  output logic              irq
);

  hold_flags_t f_q, f_n;
  logic        data_we;

  always_comb begin
    f_n     = f_q;
    data_we = 1'b0;
    if (rd_data) begin
      if (f_q.ovr_pend) begin
        f_n.ovr_vis  = 1'b1;
        f_n.brk_vis  = f_q.brk_pend;
        f_n.ovr_pend = 1'b0;
        f_n.brk_pend = 1'b0;
        f_n.seen     = 1'b0;
      end else if (f_q.ovr_vis) begin
        if (f_q.seen) f_n = '0;
      end else begin
        f_n.rda  = 1'b0;
        f_n.ferr = 1'b0;
        f_n.brk  = 1'b0;
      end
    end else if (rd_stat && f_q.ovr_vis) begin
      f_n.seen = 1'b1;
    end
    if (ld) begin
      if (f_n.rda) begin
        f_n.ovr_pend = 1'b1;
        f_n.brk_pend = f_n.brk_pend | ld_brk;
      end else begin
        data_we  = 1'b1;
        f_n.rda  = 1'b1;
        f_n.ferr = ld_ferr;
        f_n.brk  = ld_brk;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) f_q <= '0;
    else        f_q <= f_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       data_q <= '0;
    else if (data_we) data_q <= ld_data;
  end

  assign stat = {f_q.ferr, f_q.brk | f_q.brk_vis, f_q.ovr_vis, f_q.rda};
  assign irq  = (f_q.rda & rda_ie) | f_q.ovr_pend | f_q.ovr_vis
              | f_q.ferr | f_q.brk | f_q.brk_vis;

endmodule

// File: rtl/uart_rx_ovp.sv
module uart_rx_ovp
  import uart_rx_ovp_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int OVS         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              rx_i,
  input  logic              reg_rd,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq_o
);

  localparam logic [1:0] A_DATA = 2'd0;
  localparam logic [1:0] A_STAT = 2'd1;
  localparam logic [1:0] A_CTRL = 2'd2;
  localparam logic [1:0] A_MTCH = 2'd3;

  logic              rst_q, rx_s;
  logic              frm_done, frm_tag, frm_stop, frm_brk, frm_acc;
  logic [DATA_W-1:0] frm_data, data_q;
  logic [STAT_W-1:0] stat4;
  logic [1:0]        ctrl_q, ctrl_n;
  logic [DATA_W-1:0] match_q, match_n;
  logic              matched_q, matched_n;
  logic              rd_data, rd_stat, mp_en;

  uart_rx_ovp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_q));

  uart_rx_ovp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_rx_sync (
    .clk(clk), .rst_n(rst_q), .d(rx_i), .q(rx_s));

  assign mp_en   = ctrl_q[1];
  assign rd_data = reg_rd && (reg_addr == A_DATA);
  assign rd_stat = reg_rd && (reg_addr == A_STAT);

  uart_rx_ovp_deser #(.DATA_W(DATA_W), .OVS(OVS)) u_deser (
    .clk(clk), .rst_n(rst_q), .tick(baud_tick), .rx(rx_s), .mp_en(mp_en),
    .done(frm_done), .data(frm_data), .tag(frm_tag), .stop_ok(frm_stop),
    .brk(frm_brk));

  assign frm_acc = frm_done && (!mp_en || (!frm_tag && matched_q));

  uart_rx_ovp_hold #(.DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst_n(rst_q), .ld(frm_acc), .ld_data(frm_data),
    .ld_ferr(!frm_stop), .ld_brk(frm_brk), .rd_data(rd_data),
    .rd_stat(rd_stat), .rda_ie(ctrl_q[0]), .data_q(data_q), .stat(stat4),
    .irq(irq_o));

  always_comb begin
    ctrl_n    = ctrl_q;
    match_n   = match_q;
    matched_n = matched_q;
    if (reg_wr && reg_addr == A_CTRL) ctrl_n  = reg_wdata[1:0];
    if (reg_wr && reg_addr == A_MTCH) match_n = reg_wdata;
    if (frm_done && mp_en && frm_tag && frm_stop)
      matched_n = (frm_data == match_q);
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      ctrl_q    <= '0;
      match_q   <= '0;
      matched_q <= 1'b0;
    end else begin
      ctrl_q    <= ctrl_n;
      match_q   <= match_n;
      matched_q <= matched_n;
    end
  end

  always_comb begin
    unique case (reg_addr)
      A_DATA:  reg_rdata = data_q;
      A_STAT:  reg_rdata = DATA_W'(stat4);
      A_CTRL:  reg_rdata = DATA_W'(ctrl_q);
      default: reg_rdata = match_q;
    endcase
  end

endmodule

// File: rtl/uart_rx_ovp_chk.sv
module uart_rx_ovp_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_data,
  input logic              frm_acc,
  input logic [DATA_W-1:0] data_q,
  input logic [3:0]        stat,
  input logic              irq
);

  // R5: an unread held byte survives a completing frame
  a_r5_hold_data: assert property (@(posedge clk) disable iff (!rst_n)
    (stat[0] && !rd_data && frm_acc) |=> $stable(data_q));

  // R5: overrun bit cannot appear without a data read
  a_r5_ovr_hidden: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat[1] && !rd_data) |=> !stat[1]);

  // R7: overrun bit only clears on a data read
  a_r7_clear_by_read: assert property (@(posedge clk) disable iff (!rst_n)
    (stat[1] && !rd_data) |=> stat[1]);

  // R1: data-available only rises after an accepted frame
  a_r1_rda_after_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat[0] && !frm_acc) |=> !stat[0]);

  // R6: a shown overrun keeps the interrupt high
  a_r6_ovr_irq: assert property (@(posedge clk) disable iff (!rst_n)
    stat[1] |-> irq);

  // R3: a framing fault keeps the interrupt high
  a_r3_ferr_irq: assert property (@(posedge clk) disable iff (!rst_n)
    stat[3] |-> irq);

endmodule

bind uart_rx_ovp uart_rx_ovp_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_data(rd_data), .frm_acc(frm_acc),
  .data_q(data_q), .stat(stat4), .irq(irq_o));

// File: tb/uart_rx_ovp_tb_top.sv
`timescale 1ns/1ps
module uart_rx_ovp_tb_top;

  localparam int BIT_CLK = 32;  // 16 ticks, one tick every 2 clocks

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       baud_tick = 1'b0;
  logic       rx_i = 1'b1;
  logic       reg_rd = 1'b0;
  logic       reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       irq_o;

  int n_chk = 0;
  int n_err = 0;
  bit quiet = 1'b0;
  bit finished = 1'b0;

  // behavioural reference state
  bit [7:0] m_data, m_match;
  bit m_rda, m_ferr, m_brk, m_ovp, m_brkp, m_ovr, m_brkv, m_seen;
  bit m_ie, m_mp, m_hit;

  always #5 clk = ~clk;

  uart_rx_ovp dut_i (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .rx_i(rx_i),
    .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o));

  initial begin
    forever begin
      @(posedge clk);
      #2 baud_tick = ~baud_tick;
    end
  end

  function automatic bit [7:0] m_status();
    return {4'b0, m_ferr, m_brk | m_brkv, m_ovr, m_rda};
  endfunction

  function automatic bit m_irq();
    return (m_rda & m_ie) | m_ovp | m_ovr | m_ferr | m_brk | m_brkv;
  endfunction

  task automatic m_frame(input bit [7:0] b, input bit a9, input bit stop);
    bit brk;
    brk = (b == 8'h00) && !a9 && !stop;
    if (m_mp) begin
      if (a9) begin
        if (stop) m_hit = (b == m_match);
        return;
      end
      if (!m_hit) return;
    end
    if (m_rda) begin
      m_ovp = 1'b1;
      m_brkp = m_brkp | brk;
    end else begin
      m_data = b; m_rda = 1'b1; m_ferr = !stop; m_brk = brk;
    end
  endtask

  task automatic m_read_data();
    if (m_ovp) begin
      m_ovr = 1'b1; m_brkv = m_brkp; m_ovp = 1'b0; m_brkp = 1'b0; m_seen = 1'b0;
    end else if (m_ovr) begin
      if (m_seen) begin
        m_ovr = 0; m_brkv = 0; m_rda = 0; m_ferr = 0; m_brk = 0; m_seen = 0;
      end
    end else begin
      m_rda = 1'b0; m_ferr = 1'b0; m_brk = 1'b0;
    end
  endtask

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // interrupt compared with the model on every clock while the line is quiet
  always @(negedge clk) begin
    if (quiet && !finished) begin
      n_chk++;
      if (irq_o !== m_irq()) begin
        n_err++;
        $display("FAIL R2 irq per-cycle: actual=%0b expected=%0b", irq_o, m_irq());
      end
    end
  end

  task automatic rd_reg(input bit [1:0] a, output bit [7:0] v);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    #1 v = reg_rdata;
    @(posedge clk);
    if (a == 2'd0) m_read_data();
    else if (a == 2'd1 && m_ovr) m_seen = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic wr_reg(input bit [1:0] a, input bit [7:0] v);
    @(negedge clk);
    reg_addr = a; reg_wdata = v; reg_wr = 1'b1;
    @(posedge clk);
    if (a == 2'd2) begin m_ie = v[0]; m_mp = v[1]; end
    if (a == 2'd3) m_match = v;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic align();
    @(negedge clk);
    while (baud_tick) @(negedge clk);
  endtask

  task automatic send_raw(input bit [7:0] b, input bit a9, input bit stop,
                          input int low_extra);
    rx_i = 1'b0;
    repeat (BIT_CLK) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rx_i = b[i];
      repeat (BIT_CLK) @(negedge clk);
    end
    if (m_mp) begin
      rx_i = a9;
      repeat (BIT_CLK) @(negedge clk);
    end
    rx_i = stop;
    repeat (BIT_CLK) @(negedge clk);
    if (!stop) repeat (low_extra) @(negedge clk);
    rx_i = 1'b1;
    repeat (40) @(negedge clk);
  endtask

  task automatic send_frame(input bit [7:0] b, input bit a9, input bit stop,
                            input int low_extra);
    quiet = 1'b0;
    align();
    send_raw(b, a9, stop, low_extra);
    m_frame(b, a9, stop);
    quiet = 1'b1;
  endtask

  task automatic expect_stat(input string tag);
    bit [7:0] v;
    rd_reg(2'd1, v);
    check(v == m_status(), tag, v, m_status());
  endtask

  task automatic expect_data(input string tag, input bit [7:0] exp);
    bit [7:0] v;
    rd_reg(2'd0, v);
    check(v == exp, tag, v, exp);
  endtask

  initial begin
    bit [7:0] v;
    int k;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    quiet = 1'b1;

    // R10: reset state and register access
    check(irq_o == 1'b0, "R10 irq after reset", irq_o, 0);
    rd_reg(2'd1, v); check(v == 8'h00, "R10 status after reset", v, 0);
    rd_reg(2'd2, v); check(v == 8'h00, "R10 control after reset", v, 0);
    wr_reg(2'd3, 8'h42);
    rd_reg(2'd3, v); check(v == 8'h42, "R10 match readback", v, 8'h42);
    wr_reg(2'd2, 8'h01);
    rd_reg(2'd2, v); check(v == 8'h01, "R10 control readback", v, 1);

    // R1/R2: plain reception, LSB first, interrupt with enable set
    send_frame(8'hA5, 1'b0, 1'b1, 0);
    check(irq_o == 1'b1, "R2 irq on data with enable", irq_o, 1);
    expect_stat("R1 status after frame");
    expect_data("R1 received byte", 8'hA5);
    expect_stat("R1 status after data read");

    // R2: enable clear masks the data source
    wr_reg(2'd2, 8'h00);
    send_frame(8'h3C, 1'b0, 1'b1, 0);
    check(irq_o == 1'b0, "R2 irq masked", irq_o, 0);
    expect_stat("R2 status with mask");
    expect_data("R2 masked byte", 8'h3C);

    // R1: short glitch rejected
    align();
    rx_i = 1'b0; repeat (6) @(negedge clk); rx_i = 1'b1;
    repeat (400) @(negedge clk);
    expect_stat("R1 glitch ignored");

    // R3: framing fault, interrupt despite mask
    send_frame(8'h5A, 1'b0, 1'b0, 0);
    check(irq_o == 1'b1, "R3 irq on framing fault", irq_o, 1);
    expect_stat("R3 framing status");
    expect_data("R3 byte with fault", 8'h5A);
    expect_stat("R3 cleared by read");

    // R4: break, line held low for several bit times
    send_frame(8'h00, 1'b0, 1'b0, 200);
    expect_stat("R4 break status");
    expect_data("R4 break byte", 8'h00);
    expect_stat("R4 no frame while low");

    // R5/R6/R7: overrun
    wr_reg(2'd2, 8'h01);
    send_frame(8'h11, 1'b0, 1'b1, 0);
    send_frame(8'h22, 1'b0, 1'b1, 0);
    expect_stat("R5 overrun hidden");
    check(irq_o == 1'b1, "R5 irq on overrun", irq_o, 1);
    expect_data("R6 held byte kept", 8'h11);
    expect_data("R7 early data read", 8'h11);
    expect_stat("R6 overrun shown");
    expect_data("R7 second read", 8'h11);
    expect_stat("R7 cleared");
    expect_data("R7 register unchanged", 8'h11);

    // R6: overrun caused by a break
    send_frame(8'h44, 1'b0, 1'b1, 0);
    send_frame(8'h00, 1'b0, 1'b0, 0);
    expect_stat("R6 break overrun hidden");
    expect_data("R6 held byte", 8'h44);
    expect_stat("R6 break with overrun");
    expect_data("R7 clear after break", 8'h44);
    expect_stat("R7 break cleared");

    // R8: read and completion in the same cycle
    quiet = 1'b0;
    align();
    k = 0;
    fork
      send_raw(8'h7E, 1'b0, 1'b1, 0);
      begin
        while (k < 2000) begin
          @(posedge clk); k++;
          @(negedge clk);
          if (irq_o) break;
        end
      end
    join
    m_frame(8'h7E, 1'b0, 1'b1);
    quiet = 1'b1;
    expect_data("R8 timing frame", 8'h7E);
    send_frame(8'h31, 1'b0, 1'b1, 0);
    quiet = 1'b0;
    align();
    fork
      send_raw(8'hC6, 1'b0, 1'b1, 0);
      begin
        repeat (k - 1) @(posedge clk);
        @(negedge clk);
        reg_addr = 2'd0; reg_rd = 1'b1;
        #1 v = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
      end
    join
    m_read_data();
    m_frame(8'hC6, 1'b0, 1'b1);
    quiet = 1'b1;
    check(v == 8'h31, "R8 read returns old byte", v, 8'h31);
    expect_stat("R8 no overrun");
    expect_data("R8 new byte stored", 8'hC6);

    // R9: addressed mode
    wr_reg(2'd2, 8'h03);
    send_frame(8'h77, 1'b0, 1'b1, 0);
    expect_stat("R9 data before address dropped");
    send_frame(8'h13, 1'b1, 1'b1, 0);
    send_frame(8'h55, 1'b0, 1'b1, 0);
    expect_stat("R9 data after wrong address dropped");
    send_frame(8'h42, 1'b1, 1'b1, 0);
    expect_stat("R9 address not stored");
    send_frame(8'h99, 1'b0, 1'b1, 0);
    expect_stat("R9 data after match");
    expect_data("R9 matched byte", 8'h99);
    send_frame(8'h13, 1'b1, 1'b1, 0);
    send_frame(8'h66, 1'b0, 1'b1, 0);
    expect_stat("R9 match cleared");
    expect_data("R9 register keeps byte", 8'h99);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

endmodule